// File: doc/BRIEF.md
# Byte Nonvolatile Store Access Controller

This block sits between a small processor register interface and an on-chip, byte-wide nonvolatile data store. Here the store is an internal array. Software sees four byte-wide registers chosen by a 2-bit select: two registers hold the byte address, one holds the data, and one is a control register. Each access moves exactly one byte. A read is started from the control register. It copies the addressed byte into the data register and holds the processor stall line for a fixed number of cycles.

A write is guarded so that a single stray register write cannot change the store. Software first sets an arm bit, which opens a short window that closes by itself. A write strobe only has effect while that window is open. A started write is self-timed by a parameterised cycle counter. While the counter runs, a busy flag is shown to software, and the block ignores further strobes and any change to the address or data registers. A separate write stall, shorter than the read stall, holds the processor. An optional interrupt line reports that the store is idle whenever its enable bit is set.

Top module: `nvb_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, `cpu_stall`, `nv_busy` and `nv_irq` are low, and the address, data and control registers all read back as zero.
- R2: `bus_sel` picks the register on both write and readback. 0 is the low address byte, 1 is the high address bits (zero-extended), 2 is data and 3 is control. `bus_rdata` follows `bus_sel` with no clock delay. The control readback is: bit 1 = busy, bit 2 = arm, bit 3 = interrupt enable, all other bits zero.
- R3: A control write with bit 0 set, while the store is idle, starts a read. `cpu_stall` is high for exactly RD_STALL (4) cycles, from the cycle after the strobe edge. The addressed byte is in the data register when the stall ends.
- R4: In simulation the array starts as all ones. Its contents are kept through reset.
- R5: A control write with bit 1 set while armed writes the data register to the addressed byte. `cpu_stall` is then high for WR_STALL (2) cycles, and `nv_busy` (also control bit 1) is high for WRITE_CYCLES (40) cycles, both from the cycle after the strobe edge.
- R6: A control write with bit 2 set arms the block for ARM_WINDOW (4) cycles. A write strobe on any of the next 4 clock edges starts the write. The arm bit clears itself when the window ends or when a write starts. A write strobe without arm, in the same write that sets arm, or after the window has closed does nothing.
- R7: While busy, read and write strobes are ignored. The write timer is not restarted.
- R8: While busy, writes to the address and data registers are ignored.
- R9: Interrupt enable is control bit 3 and is rewritten by every control write. `nv_irq` equals (enable AND NOT busy) delayed by one cycle.
- R10: If one control write sets both bit 0 and bit 1, the write wins when the block is armed. When it is not armed, the read takes place.
- R11: Every address from 0 to DEPTH-1 selects its own byte. The lowest and highest addresses do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register readback for the selected register |
| cpu_stall | output | 1 | Holds the processor after an access |
| nv_busy | output | 1 | Self-timed write in progress |
| nv_irq | output | 1 | Store idle while interrupt is enabled |

## Verification
Every result has a fixed due cycle, counted from the clock edge that takes the control write. Stall and busy rise after that edge and last 4, 2 and 40 cycles. The read byte is in the data register two edges later, and the interrupt line lags enable and busy by one edge. The bench drives and samples on the falling edge. It counts falling edges while stall or busy is high and compares the totals. For the arm window, it places the strobe on exactly the fourth and fifth edge after arming. For the busy-time strobe, it checks that the remaining busy count is the original total minus the edges already spent.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [1:0] {
    SEL_ADRL = 2'd0,
    SEL_ADRH = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } nvb_sel_e;

  // control register bit positions
  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_ARM = 2;
  localparam int CB_IE  = 3;

  function automatic logic [7:0] ctrl_image(input logic ie, input logic arm, input logic busy);
    logic [7:0] img;
    img         = '0;
    img[CB_IE]  = ie;
    img[CB_ARM] = arm;
    img[CB_WR]  = busy;
    return img;
  endfunction

endpackage

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // simulation power-up image: erased cells read as all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // synchronous read port, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
  parameter int WRITE_CYCLES = 40,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic wr_go,
  output logic busy_o,
  output logic stall_o,
  output logic rd_load_o
);

  localparam int BW   = $clog2(WRITE_CYCLES + 1);
  localparam int SMAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW   = $clog2(SMAX + 1);

  logic [BW-1:0] bcnt;
  logic [SW-1:0] scnt;

  // write duration counter
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      bcnt   <= '0;
    end else if (wr_go) begin
      busy_o <= 1'b1;
      bcnt   <= BW'(WRITE_CYCLES);
    end else if (busy_o) begin
      if (bcnt == BW'(1)) busy_o <= 1'b0;
      bcnt <= bcnt - BW'(1);
    end
  end

  // processor stall counter, length picked by access kind
  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o <= 1'b0;
      scnt    <= '0;
    end else if (wr_go || rd_go) begin
      stall_o <= 1'b1;
      scnt    <= wr_go ? SW'(WR_STALL) : SW'(RD_STALL);
    end else if (stall_o) begin
      if (scnt == SW'(1)) stall_o <= 1'b0;
      scnt <= scnt - SW'(1);
    end
  end

  // array read data lands one cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst) rd_load_o <= 1'b0;
    else     rd_load_o <= rd_go;
  end

  assert_busy_from_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(wr_go));

  assert_no_strobe_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !(rd_go || wr_go));

  assert_read_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> stall_o);

endmodule

// File: rtl/nvb_regs.sv
module nvb_regs
  import nvb_pkg::*;
#(
  parameter int AW         = 10,
  parameter int ARM_WINDOW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [7:0]    bus_wdata,
  input  logic          busy_i,
  input  logic          rd_load_i,
  input  logic [7:0]    rd_byte_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          rd_go_o,
  output logic          wr_go_o,
  output logic          ie_o,
  output logic [7:0]    bus_rdata_o
);

  localparam int HW = AW - 8;
  localparam int WW = $clog2(ARM_WINDOW + 1);

  logic          arm_q;
  logic [WW-1:0] win_q;
  logic          ctrl_wr;

  assign ctrl_wr = bus_we && (bus_sel == SEL_CTRL);
  assign wr_go_o = ctrl_wr && bus_wdata[CB_WR] && arm_q && !busy_i;
  assign rd_go_o = ctrl_wr && bus_wdata[CB_RD] && !busy_i && !wr_go_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      data_o <= '0;
      ie_o   <= 1'b0;
      arm_q  <= 1'b0;
      win_q  <= '0;
    end else begin
      if (bus_we && !busy_i) begin
        case (nvb_sel_e'(bus_sel))
          SEL_ADRL: addr_o[7:0]    <= bus_wdata;
          SEL_ADRH: addr_o[AW-1:8] <= bus_wdata[HW-1:0];
          SEL_DATA: data_o         <= bus_wdata;
          default:  ;
        endcase
      end
      if (rd_load_i) data_o <= rd_byte_i;
      if (ctrl_wr) ie_o <= bus_wdata[CB_IE];
      // guarded write window
      if (wr_go_o) begin
        arm_q <= 1'b0;
        win_q <= '0;
      end else if (ctrl_wr && bus_wdata[CB_ARM]) begin
        arm_q <= 1'b1;
        win_q <= WW'(ARM_WINDOW);
      end else if (arm_q) begin
        if (win_q == WW'(1)) arm_q <= 1'b0;
        win_q <= win_q - WW'(1);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (nvb_sel_e'(bus_sel))
      SEL_ADRL: bus_rdata_o = addr_o[7:0];
      SEL_ADRH: bus_rdata_o[HW-1:0] = addr_o[AW-1:8];
      SEL_DATA: bus_rdata_o = data_o;
      default:  bus_rdata_o = ctrl_image(ie_o, arm_q, busy_i);
    endcase
  end

  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(addr_o) && $stable(data_o)));

  assert_write_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[CB_WR] && !arm_q) |=> !busy_i || $past(busy_i));

endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int WRITE_CYCLES = 40,
  parameter int ARM_WINDOW   = 4,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_stall,
  output logic       nv_busy,
  output logic       nv_irq
);

  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] addr;
  logic [7:0]    data;
  logic [7:0]    arr_q;
  logic          rd_go, wr_go, rd_load, ie;
  logic          irq_q;

  nvb_regs #(.AW(AW), .ARM_WINDOW(ARM_WINDOW)) regs_i (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .busy_i(nv_busy), .rd_load_i(rd_load), .rd_byte_i(arr_q),
    .addr_o(addr), .data_o(data),
    .rd_go_o(rd_go), .wr_go_o(wr_go), .ie_o(ie),
    .bus_rdata_o(bus_rdata)
  );

  nvb_timer #(.WRITE_CYCLES(WRITE_CYCLES), .RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) timer_i (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .wr_go(wr_go),
    .busy_o(nv_busy), .stall_o(cpu_stall), .rd_load_o(rd_load)
  );

  nvb_array #(.DEPTH(DEPTH), .AW(AW)) array_i (
    .clk(clk), .we(wr_go), .re(rd_go),
    .addr(addr), .wdata(data), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ie && !nv_busy;
  end
  assign nv_irq = irq_q;

  assert_irq_quiet_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    nv_busy |=> !nv_irq);

  assert_stall_idle_no_access_R3: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stall && !rd_go && !wr_go) |=> !cpu_stall);

endmodule

// File: tb/nvb_ctrl_tb.sv
module nvb_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cpu_stall, nv_busy, nv_irq;

  int total = 0;
  int fails = 0;

  // {address, data} pairs written then read back
  localparam logic [17:0] VEC [0:7] = '{
    {10'd0,    8'h5A}, {10'd1023, 8'hA5}, {10'd512, 8'h3C}, {10'd255, 8'h00},
    {10'd256,  8'h81}, {10'd1,    8'h12}, {10'd767, 8'hC3}, {10'd100, 8'h7E}
  };

  nvb_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_stall(cpu_stall), .nv_busy(nv_busy), .nv_irq(nv_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic bw(input logic [1:0] s, input logic [7:0] d);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  task automatic set_addr(input logic [9:0] a);
    bw(2'd0, a[7:0]);
    bw(2'd1, {6'd0, a[9:8]});
  endtask

  task automatic measure_busy(output int nb, output int ns);
    nb = 0; ns = 0;
    while (nv_busy && nb < 1000) begin
      if (cpu_stall) ns++;
      nb++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d, output int nb, output int ns);
    set_addr(a);
    bw(2'd2, d);
    bw(2'd3, 8'h04);
    bw(2'd3, 8'h02);
    measure_busy(nb, ns);
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] v, output int ns);
    set_addr(a);
    bw(2'd3, 8'h01);
    ns = 0;
    while (cpu_stall && ns < 100) begin
      ns++;
      @(negedge clk);
    end
    peek(2'd2, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int nb, ns;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 stall", int'(cpu_stall), 0);
    chk("R1 busy", int'(nv_busy), 0);
    chk("R1 irq", int'(nv_irq), 0);
    peek(2'd3, v); chk("R1 ctrl", v, 0);
    peek(2'd0, v); chk("R1 addr", v, 0);
    peek(2'd2, v); chk("R1 data", v, 0);

    // R4 erased image, R3 read stall length
    do_read(10'd300, v, ns);
    chk("R4 erased byte", v, 8'hFF);
    chk("R3 read stall", ns, 4);
    peek(2'd1, v); chk("R2 addr high", v, 1);
    peek(2'd0, v); chk("R2 addr low", v, 8'h2C);

    // vector table: R5 writes, R11 distinct addresses
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][17:8], VEC[i][7:0], nb, ns);
      chk("R5 busy length", nb, WCYC);
      chk("R5 write stall", ns, 2);
    end
    for (int i = 0; i < 8; i++) begin
      do_read(VEC[i][17:8], v, ns);
      chk("R11 readback", v, VEC[i][7:0]);
      chk("R3 read stall", ns, 4);
    end

    // R6 strobe without arm
    set_addr(10'd300);
    bw(2'd2, 8'h11);
    bw(2'd3, 8'h02);
    chk("R6 unarmed strobe", int'(nv_busy), 0);

    // R6 arm readback and self clear
    bw(2'd3, 8'h04);
    peek(2'd3, v); chk("R6 arm set", v, 8'h04);
    repeat (4) @(negedge clk);
    peek(2'd3, v); chk("R6 arm cleared", v, 8'h00);

    // R6 strobe on the fifth edge is too late
    bw(2'd3, 8'h04);
    repeat (4) @(negedge clk);
    bw(2'd3, 8'h02);
    chk("R6 late strobe", int'(nv_busy), 0);
    do_read(10'd300, v, ns);
    chk("R6 late strobe data", v, 8'hFF);

    // R6 strobe on the fourth edge works, arm consumed
    bw(2'd2, 8'h11);
    bw(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    bw(2'd3, 8'h02);
    chk("R6 last window strobe", int'(nv_busy), 1);
    peek(2'd3, v); chk("R5 busy bit, R6 arm consumed", v, 8'h02);
    measure_busy(nb, ns);
    do_read(10'd300, v, ns);
    chk("R6 window write data", v, 8'h11);

    // R6 arm and strobe in the same write
    set_addr(10'd301);
    bw(2'd2, 8'h22);
    bw(2'd3, 8'h06);
    chk("R6 same-write strobe", int'(nv_busy), 0);
    repeat (5) @(negedge clk);
    do_read(10'd301, v, ns);
    chk("R6 same-write data", v, 8'hFF);

    // R7 R8 accesses while busy
    set_addr(10'd302);
    bw(2'd2, 8'h33);
    bw(2'd3, 8'h04);
    bw(2'd3, 8'h02);
    bw(2'd0, 8'h55);
    peek(2'd0, v); chk("R8 addr held", v, 8'h2E);
    bw(2'd2, 8'h99);
    peek(2'd2, v); chk("R8 data held", v, 8'h33);
    bw(2'd3, 8'h01);
    chk("R7 read ignored", int'(cpu_stall), 0);
    bw(2'd3, 8'h04);
    bw(2'd3, 8'h02);
    measure_busy(nb, ns);
    chk("R7 timer not restarted", nb, WCYC - 5);
    do_read(10'd302, v, ns);
    chk("R7 R8 stored byte", v, 8'h33);

    // R10 both strobe bits
    set_addr(10'd303);
    bw(2'd2, 8'h44);
    bw(2'd3, 8'h04);
    bw(2'd3, 8'h03);
    chk("R10 armed write wins", int'(nv_busy), 1);
    measure_busy(nb, ns);
    bw(2'd2, 8'h00);
    bw(2'd3, 8'h03);
    ns = 0;
    while (cpu_stall && ns < 100) begin ns++; @(negedge clk); end
    chk("R10 unarmed read stall", ns, 4);
    peek(2'd2, v); chk("R10 unarmed read data", v, 8'h44);

    // R9 interrupt
    bw(2'd3, 8'h08);
    chk("R9 irq lag", int'(nv_irq), 0);
    @(negedge clk);
    chk("R9 irq idle", int'(nv_irq), 1);
    set_addr(10'd304);
    bw(2'd2, 8'h55);
    bw(2'd3, 8'h0C);
    bw(2'd3, 8'h0A);
    @(negedge clk);
    chk("R9 irq low while busy", int'(nv_irq), 0);
    measure_busy(nb, ns);
    chk("R9 irq lags busy fall", int'(nv_irq), 0);
    @(negedge clk);
    chk("R9 irq after write", int'(nv_irq), 1);
    bw(2'd3, 8'h00);
    @(negedge clk);
    chk("R9 irq disabled", int'(nv_irq), 0);

    // R4 contents survive reset, R1 registers clear
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    peek(2'd3, v); chk("R1 ctrl after reset", v, 0);
    do_read(10'd0, v, ns);
    chk("R4 kept through reset", v, 8'h5A);
    do_read(10'd304, v, ns);
    chk("R5 irq-phase write data", v, 8'h55);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule